// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical memory address. It keeps four 16-bit segment base registers (code, stack, data, extra) and picks one of them for each reference. The chosen base is shifted left by four bits and the offset is added to it, so the result always falls in the 00000H to FFFFFH space.

The caller gives the kind of reference (instruction fetch, stack push or pop, general data, or string destination), a flag saying whether the data address is based on BP, and an optional segment override. Fixed precedence rules pick the segment. An override changes the choice only for general data references. The chosen segment index is reported next to the address.

A separate write port loads any one segment register at the next rising clock edge. The address path itself holds no registers, so the address and segment index follow the inputs and the stored bases within the same cycle.

Top module: `segaddr_gen`

## Requirements
- R1: After reset the code segment register holds FFFFH and the stack, data and extra registers hold 0000H, so a fetch at offset 0000H yields FFFF0H.
- R2: When ref_kind is 0 (instruction fetch), the code segment is used and seg_used is 0. The override inputs and bp_base have no effect.
- R3: When ref_kind is 1 (stack push or pop), the stack segment is used and seg_used is 1. The override inputs and bp_base have no effect.
- R4: When ref_kind is 2 (data), ovr_en is 0 and bp_base is 0, the data segment is used and seg_used is 2.
- R5: When ref_kind is 2, ovr_en is 0 and bp_base is 1, the stack segment is used and seg_used is 1.
- R6: When ref_kind is 2 and ovr_en is 1, the segment coded by ovr_seg (0 code, 1 stack, 2 data, 3 extra) is used whatever bp_base is, and seg_used equals ovr_seg.
- R7: When ref_kind is 3 (string destination), the extra segment is used and seg_used is 3. The override inputs and bp_base have no effect.
- R8: phys_addr equals (selected base × 16 + offset) modulo 2^20. Any carry out of bit 19 is lost, so phys_addr[3:0] always equals offset[3:0].
- R9: phys_addr and seg_used are combinational from the inputs and the stored bases. A write becomes visible only after the next rising clock edge and never in the cycle it is presented.
- R10: When wr_en is 1 at a rising edge, the register coded by wr_sel (same codes as ovr_seg) is loaded with wr_data and the other registers keep their values. When wr_en is 0, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; segment writes happen on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load the register chosen by wr_sel |
| wr_sel | input | 2 | Register to load: 0 code, 1 stack, 2 data, 3 extra |
| wr_data | input | 16 | New segment base value |
| ref_kind | input | 2 | Reference kind: 0 fetch, 1 stack, 2 data, 3 string destination |
| ovr_en | input | 1 | Request a segment override |
| ovr_seg | input | 2 | Segment code of the override |
| bp_base | input | 1 | Data address is BP-based |
| offset | input | 16 | Offset within the segment |
| phys_addr | output | 20 | Physical address |
| seg_used | output | 2 | Index of the segment that formed phys_addr |

## Verification
The segment index and the physical address settle in the same cycle as their inputs. The bench therefore drives each stimulus on a falling edge and compares both outputs a quarter period later, before the next rising edge. A register write counts as done only after that rising edge. The bench's model applies the write only after the edge, and every read in the cycle of a write is checked against the old base. Random traffic over all kinds, override codes, BP flags, offsets and writes is mixed with directed cases: the reset values, address wrap at the top of the space, and a read of a register in the same cycle it is written.

// File: rtl/segaddr_pkg.sv
package segaddr_pkg;

    localparam int SEG_W  = 16;
    localparam int OFF_W  = 16;
    localparam int SHIFT  = 4;
    localparam int NSEG   = 4;
    localparam int ADDR_W = SEG_W + SHIFT;
    localparam int SEL_W  = $clog2(NSEG);

    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_STACK = 2'd1,
        SEG_DATA  = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_id_t;

    typedef enum logic [1:0] {
        KIND_FETCH  = 2'd0,
        KIND_STACK  = 2'd1,
        KIND_DATA   = 2'd2,
        KIND_STRDST = 2'd3
    } ref_kind_t;

endpackage

// File: rtl/segaddr_bank.sv
module segaddr_bank #(
    parameter int SEG_W    = segaddr_pkg::SEG_W,
    parameter int NSEG     = segaddr_pkg::NSEG,
    parameter int CODE_IDX = 0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [$clog2(NSEG)-1:0]      wr_sel,
    input  logic [SEG_W-1:0]             wr_data,
    output logic [NSEG-1:0][SEG_W-1:0]   bank
);
    localparam int SEL_W = $clog2(NSEG);

    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        localparam logic [SEG_W-1:0] RST_VAL = (i == CODE_IDX) ? {SEG_W{1'b1}} : {SEG_W{1'b0}};
        logic [SEG_W-1:0] q;
        logic             hit;

        assign hit = wr_en && (wr_sel == SEL_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= RST_VAL;
            end else if (hit) begin
                q <= wr_data;
            end
        end

        assign bank[i] = q;
    end

    // R10: a write lands in the register that was selected
    assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> bank[$past(wr_sel)] == $past(wr_data));

    // R10: without a write enable nothing moves
    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank));

    // R1: reset values are seen at the first edge after release
    assert_reset_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> bank[CODE_IDX] == {SEG_W{1'b1}});

endmodule

// File: rtl/segaddr_pick.sv
module segaddr_pick
    import segaddr_pkg::*;
(
    input  ref_kind_t kind,
    input  logic      ovr_en,
    input  seg_id_t   ovr_seg,
    input  logic      bp_base,
    output seg_id_t   sel
);
    seg_id_t data_default;

    always_comb begin
        data_default = bp_base ? SEG_STACK : SEG_DATA;
    end

    always_comb begin
        unique case (kind)
            KIND_FETCH:  sel = SEG_CODE;
            KIND_STACK:  sel = SEG_STACK;
            KIND_STRDST: sel = SEG_EXTRA;
            KIND_DATA:   sel = ovr_en ? ovr_seg : data_default;
            default:     sel = SEG_CODE;
        endcase
    end

endmodule

// File: rtl/segaddr_form.sv
module segaddr_form #(
    parameter int SEG_W = segaddr_pkg::SEG_W,
    parameter int OFF_W = segaddr_pkg::OFF_W,
    parameter int SHIFT = segaddr_pkg::SHIFT
) (
    input  logic [SEG_W-1:0]       seg_base,
    input  logic [OFF_W-1:0]       offset,
    output logic [SEG_W+SHIFT-1:0] phys
);
    localparam int ADDR_W = SEG_W + SHIFT;

    logic [ADDR_W-1:0] base_shifted;
    logic [ADDR_W-1:0] off_ext;

    assign base_shifted = {seg_base, {SHIFT{1'b0}}};
    assign off_ext      = ADDR_W'(offset);
    assign phys         = base_shifted + off_ext;

endmodule

// File: rtl/segaddr_gen.sv
module segaddr_gen
    import segaddr_pkg::*;
#(
    parameter int SEG_W_P = SEG_W,
    parameter int OFF_W_P = OFF_W,
    parameter int SHIFT_P = SHIFT
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [1:0]                 wr_sel,
    input  logic [SEG_W_P-1:0]         wr_data,
    input  logic [1:0]                 ref_kind,
    input  logic                       ovr_en,
    input  logic [1:0]                 ovr_seg,
    input  logic                       bp_base,
    input  logic [OFF_W_P-1:0]         offset,
    output logic [SEG_W_P+SHIFT_P-1:0] phys_addr,
    output logic [1:0]                 seg_used
);
    localparam int ADDR_W_P = SEG_W_P + SHIFT_P;

    logic [NSEG-1:0][SEG_W_P-1:0] bank;
    seg_id_t                      sel;
    logic [SEG_W_P-1:0]           base_sel;

    segaddr_bank #(.SEG_W(SEG_W_P), .NSEG(NSEG), .CODE_IDX(int'(SEG_CODE))) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .bank    (bank)
    );

    segaddr_pick u_pick (
        .kind    (ref_kind_t'(ref_kind)),
        .ovr_en  (ovr_en),
        .ovr_seg (seg_id_t'(ovr_seg)),
        .bp_base (bp_base),
        .sel     (sel)
    );

    assign base_sel = bank[sel];

    segaddr_form #(.SEG_W(SEG_W_P), .OFF_W(OFF_W_P), .SHIFT(SHIFT_P)) u_form (
        .seg_base (base_sel),
        .offset   (offset),
        .phys     (phys_addr)
    );

    assign seg_used = sel;

    assert_fetch_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ref_kind == 2'd0 |-> seg_used == 2'd0);

    assert_stack_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_kind == 2'd1 |-> seg_used == 2'd1);

    assert_data_plain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_kind == 2'd2 && !ovr_en && !bp_base) |-> seg_used == 2'd2);

    assert_data_bp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_kind == 2'd2 && !ovr_en && bp_base) |-> seg_used == 2'd1);

    assert_override_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_kind == 2'd2 && ovr_en) |-> seg_used == ovr_seg);

    assert_strdst_extra_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ref_kind == 2'd3 |-> seg_used == 2'd3);

    assert_low_nibble_R8: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[SHIFT_P-1:0] == offset[SHIFT_P-1:0]);

    assert_addr_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(phys_addr) && ADDR_W_P == SEG_W_P + SHIFT_P);

endmodule

// File: tb/segaddr_gen_bench.sv
module segaddr_gen_bench;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  ref_kind = '0;
    logic        ovr_en = 1'b0;
    logic [1:0]  ovr_seg = '0;
    logic        bp_base = 1'b0;
    logic [15:0] offset = '0;
    logic [19:0] phys_addr;
    logic [1:0]  seg_used;

    int checks = 0;
    int failures = 0;
    logic [15:0] model [4];

    always #(PERIOD/2) clk = ~clk;

    segaddr_gen u_segaddr_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ref_kind(ref_kind), .ovr_en(ovr_en), .ovr_seg(ovr_seg), .bp_base(bp_base),
        .offset(offset), .phys_addr(phys_addr), .seg_used(seg_used)
    );

    function automatic logic [1:0] exp_seg(logic [1:0] k, logic oe, logic [1:0] os, logic bp);
        case (k)
            2'd0: return 2'd0;
            2'd1: return 2'd1;
            2'd3: return 2'd3;
            default: return oe ? os : (bp ? 2'd1 : 2'd2);
        endcase
    endfunction

    function automatic logic [19:0] exp_addr(logic [15:0] s, logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    function automatic string auto_tag(logic [1:0] k, logic oe, logic bp);
        case (k)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd3: return "R7";
            default: return oe ? "R6" : (bp ? "R5" : "R4");
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(logic [1:0] k, logic oe, logic [1:0] os, logic bp, logic [15:0] off,
                         logic we, logic [1:0] ws, logic [15:0] wd, string tag);
        logic [1:0] es;
        string      t;
        @(negedge clk);
        ref_kind = k; ovr_en = oe; ovr_seg = os; bp_base = bp; offset = off;
        wr_en = we; wr_sel = ws; wr_data = wd;
        #(PERIOD/4);
        es = exp_seg(k, oe, os, bp);
        t  = (tag == "") ? auto_tag(k, oe, bp) : tag;
        check(t, 32'(seg_used), 32'(es));
        check((tag == "") ? "R8" : tag, 32'(phys_addr), 32'(exp_addr(model[es], off)));
        @(posedge clk);
        #1;
        if (we) model[ws] = wd;
        wr_en = 1'b0;
    endtask

    initial begin
        #(PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model[0] = 16'hFFFF; model[1] = '0; model[2] = '0; model[3] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values observed through the address path
        apply(2'd0, 1'b0, 2'd0, 1'b0, 16'h0000, 1'b0, 2'd0, 16'h0, "R1");
        apply(2'd2, 1'b1, 2'd1, 1'b0, 16'h0000, 1'b0, 2'd0, 16'h0, "R1");
        apply(2'd2, 1'b1, 2'd2, 1'b0, 16'h0000, 1'b0, 2'd0, 16'h0, "R1");
        apply(2'd2, 1'b1, 2'd3, 1'b0, 16'h0000, 1'b0, 2'd0, 16'h0, "R1");
        // R8: wrap beyond FFFFFH drops the carry (FFFF0 + FFFF -> 0FFEF)
        apply(2'd0, 1'b0, 2'd0, 1'b0, 16'hFFFF, 1'b0, 2'd0, 16'h0, "R8");
        // R10: load each register, then read it back through an override
        for (int i = 0; i < 4; i++)
            apply(2'd1, 1'b0, 2'd0, 1'b0, 16'h0010, 1'b1, 2'(i), 16'h1111 * 16'(i + 1), "R3");
        for (int i = 0; i < 4; i++)
            apply(2'd2, 1'b1, 2'(i), 1'b1, 16'h0003, 1'b0, 2'd0, 16'h0, "R10");
        // R9: the register being written still shows its old value this cycle
        apply(2'd2, 1'b1, 2'd2, 1'b0, 16'h0005, 1'b1, 2'd2, 16'hABCD, "R9");
        apply(2'd2, 1'b1, 2'd2, 1'b0, 16'h0005, 1'b0, 2'd0, 16'h0, "R9");
        // R2, R3, R7: overrides and bp_base ignored on these kinds
        apply(2'd0, 1'b1, 2'd3, 1'b1, 16'h1234, 1'b0, 2'd0, 16'h0, "R2");
        apply(2'd1, 1'b1, 2'd2, 1'b1, 16'h1234, 1'b0, 2'd0, 16'h0, "R3");
        apply(2'd3, 1'b1, 2'd0, 1'b1, 16'h1234, 1'b0, 2'd0, 16'h0, "R7");
        // R4, R5: default data choices
        apply(2'd2, 1'b0, 2'd3, 1'b0, 16'h0F0F, 1'b0, 2'd0, 16'h0, "R4");
        apply(2'd2, 1'b0, 2'd3, 1'b1, 16'h0F0F, 1'b0, 2'd0, 16'h0, "R5");

        for (int n = 0; n < 600; n++) begin
            apply(2'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 16'($urandom),
                  ($urandom % 4) == 0, 2'($urandom), 16'($urandom), "");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule